// File: doc/BRIEF.md
# Paired Integer-Register Operand Access Unit

This unit sits between the floating-point datapath of a 32-bit core and the core's integer register file. On such a core, floating-point values live in the integer registers instead of a separate FP file. A floating-point instruction that names register k therefore uses integer register k.

Single-width (32-bit) operands map one-to-one onto registers. Double-width (64-bit) operands occupy an aligned pair made of an even register and the register that follows it. The unit holds the 32 x 32-bit register file and offers three combinational read ports and one write port. Each port carries a register index and a double-width flag. The unit joins two registers into a 64-bit read value and splits a 64-bit write value across two registers.

Register zero needs special handling for pairs. A pair read of it returns zero, and a pair write to it is dropped in full. An odd index with the double-width flag set is a reserved encoding. The unit flags it on the port where it appears.

Top module: `pair_rf_unit`

## Requirements
- R1: A synchronous active-high reset clears every writable register (indices 1 to 31) to zero, so every read after reset returns zero.
- R2: A single-width read (`rd_dbl`=0) returns the indexed register in bits 31:0 and zero in bits 63:32. A single-width write changes only the indexed register, using `wr_data[31:0]`.
- R3: A single-width write to index 0 changes no register, and a single-width read of index 0 returns zero.
- R4: A double-width read at a nonzero even index k returns register k in bits 31:0 and register k+1 in bits 63:32.
- R5: A double-width write at a nonzero even index k stores `wr_data[31:0]` into register k and `wr_data[63:32]` into register k+1, and changes no other register.
- R6: A double-width read at index 0 returns all 64 bits zero, even when register 1 holds a nonzero value.
- R7: A double-width write at index 0 changes no register; in particular register 1 keeps its value.
- R8: A double-width access with an odd index (index bit 0 = 1) is reserved. The read port raises its `rd_rsvd` bit and returns zero data. An enabled write raises `wr_rsvd`. Both flags are zero in every other case.
- R9: A write flagged as reserved changes no register.
- R10: A write takes effect on the rising clock edge. A read of that register in the same cycle returns the old value, and reads in the following cycle return the new value.
- R11: The three read ports work independently. In one cycle they may use different indices and widths, each returning its own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx | input | NRD x 5 | Register index for each read port |
| rd_dbl | input | NRD | Double-width flag for each read port |
| rd_data | output | NRD x 64 | Read result for each read port |
| rd_rsvd | output | NRD | Reserved odd-pair flag for each read port |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_dbl | input | 1 | Write double-width flag |
| wr_data | input | 64 | Write value; bits 31:0 only for single-width |
| wr_rsvd | output | 1 | Reserved odd-pair flag for the write port |

## Verification
The properties assume that `wr_en`, `wr_idx`, `wr_dbl` and the read controls are known values, never X, once reset is released. They also assume reset is held high through the first clock edge, so the register array starts from a defined state. The bench drives every control from a defined value at each falling edge, starting with reset asserted at time zero. Its random phase covers odd, zero and even indices for both widths, so the reserved and zero-pair cases occur alongside ordinary traffic.

// File: rtl/pair_rf_pkg.sv
package pair_rf_pkg;

    parameter int XLEN  = 32;
    parameter int NREG  = 32;
    parameter int IDX_W = $clog2(NREG);
    parameter int DW    = 2 * XLEN;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [DW-1:0]    dword_t;
    typedef logic [IDX_W-1:0] ridx_t;

    // One write lane into the register array
    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } lane_wr_t;

    // Partner (odd) register of the aligned pair that idx starts
    function automatic ridx_t pair_partner(ridx_t idx);
        return {idx[IDX_W-1:1], 1'b1};
    endfunction

    // Odd index with double width is reserved
    function automatic logic pair_reserved(ridx_t idx, logic dbl);
        return dbl & idx[0];
    endfunction

endpackage

// File: rtl/pair_rf_storage.sv
module pair_rf_storage
    import pair_rf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  lane_wr_t                   lo_wr,
    input  lane_wr_t                   hi_wr,
    output logic [NREG-1:0][XLEN-1:0]  regs_q
);

    logic [NREG-1:0][XLEN-1:0] mem_q;

    // Entry 0 is never loaded; it stays at its reset value and reads as zero
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int r = 1; r < NREG; r++) begin
                if (hi_wr.en && hi_wr.idx == r[IDX_W-1:0]) begin
                    mem_q[r] <= hi_wr.data;
                end else if (lo_wr.en && lo_wr.idx == r[IDX_W-1:0]) begin
                    mem_q[r] <= lo_wr.data;
                end
            end
        end
    end

    always_comb begin
        regs_q    = mem_q;
        regs_q[0] = '0;
    end

endmodule

// File: rtl/pair_rf_write_ctrl.sv
module pair_rf_write_ctrl
    import pair_rf_pkg::*;
(
    input  logic     wr_en,
    input  ridx_t    wr_idx,
    input  logic     wr_dbl,
    input  dword_t   wr_data,
    output lane_wr_t lo_wr,
    output lane_wr_t hi_wr,
    output logic     wr_rsvd
);

    logic rsvd;
    logic zero_pair;

    assign rsvd      = pair_reserved(wr_idx, wr_dbl);
    assign zero_pair = wr_dbl && (wr_idx == '0);
    assign wr_rsvd   = wr_en && rsvd;

    always_comb begin
        lo_wr = '0;
        hi_wr = '0;
        if (wr_en) begin
            if (!wr_dbl) begin
                // Index 0 passes through here and is ignored by the storage
                lo_wr = '{en: 1'b1, idx: wr_idx, data: wr_data[XLEN-1:0]};
            end else if (!rsvd && !zero_pair) begin
                lo_wr = '{en: 1'b1, idx: wr_idx, data: wr_data[XLEN-1:0]};
                hi_wr = '{en: 1'b1, idx: pair_partner(wr_idx), data: wr_data[DW-1:XLEN]};
            end
        end
    end

endmodule

// File: rtl/pair_rf_read_port.sv
module pair_rf_read_port
    import pair_rf_pkg::*;
(
    input  logic [NREG-1:0][XLEN-1:0] regs_q,
    input  ridx_t                     rd_idx,
    input  logic                      rd_dbl,
    output dword_t                    rd_data,
    output logic                      rd_rsvd
);

    word_t lo_word;
    word_t hi_word;

    assign lo_word = regs_q[rd_idx];
    assign hi_word = regs_q[pair_partner(rd_idx)];
    assign rd_rsvd = pair_reserved(rd_idx, rd_dbl);

    always_comb begin
        if (!rd_dbl) begin
            rd_data = {{XLEN{1'b0}}, lo_word};
        end else if (rd_rsvd || rd_idx == '0) begin
            rd_data = '0;
        end else begin
            rd_data = {hi_word, lo_word};
        end
    end

endmodule

// File: rtl/pair_rf_unit.sv
module pair_rf_unit
    import pair_rf_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NRD-1:0][pair_rf_pkg::IDX_W-1:0] rd_idx,
    input  logic [NRD-1:0]                      rd_dbl,
    output logic [NRD-1:0][pair_rf_pkg::DW-1:0] rd_data,
    output logic [NRD-1:0]                      rd_rsvd,
    input  logic                                wr_en,
    input  logic [pair_rf_pkg::IDX_W-1:0]       wr_idx,
    input  logic                                wr_dbl,
    input  logic [pair_rf_pkg::DW-1:0]          wr_data,
    output logic                                wr_rsvd
);

    lane_wr_t                  lo_wr;
    lane_wr_t                  hi_wr;
    logic [NREG-1:0][XLEN-1:0] regs_q;

    pair_rf_write_ctrl u_wctrl (
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_dbl  (wr_dbl),
        .wr_data (wr_data),
        .lo_wr   (lo_wr),
        .hi_wr   (hi_wr),
        .wr_rsvd (wr_rsvd)
    );

    pair_rf_storage u_store (
        .clk    (clk),
        .rst    (rst),
        .lo_wr  (lo_wr),
        .hi_wr  (hi_wr),
        .regs_q (regs_q)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        pair_rf_read_port u_rport (
            .regs_q  (regs_q),
            .rd_idx  (rd_idx[p]),
            .rd_dbl  (rd_dbl[p]),
            .rd_data (rd_data[p]),
            .rd_rsvd (rd_rsvd[p])
        );

        assert_rsvd_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
            (rd_dbl[p] && rd_idx[p][0]) |-> (rd_data[p] == '0));

        assert_zero_pair_read_R6: assert property (@(posedge clk) disable iff (rst)
            (rd_dbl[p] && rd_idx[p] == '0) |-> (rd_data[p] == '0));

        assert_single_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
            !rd_dbl[p] |-> (rd_data[p][DW-1:XLEN] == '0));
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (regs_q == '0));

    assert_rsvd_write_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en && wr_dbl && wr_idx[0]) |=> $stable(regs_q));

    assert_zero_pair_write_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en && wr_dbl && wr_idx == '0) |=> $stable(regs_q));

    assert_pair_write_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en && wr_dbl && !wr_idx[0] && wr_idx != '0)
        |=> (regs_q[$past(wr_idx)] == $past(wr_data[XLEN-1:0])));

    assert_pair_write_hi_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en && wr_dbl && !wr_idx[0] && wr_idx != '0)
        |=> (regs_q[$past(wr_idx) + 1'b1] == $past(wr_data[DW-1:XLEN])));

endmodule

// File: tb/pair_rf_unit_bench.sv
`timescale 1ns/1ps
module pair_rf_unit_bench;

    localparam int NRD = 3;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NRD-1:0][4:0]   rd_idx = '0;
    logic [NRD-1:0]        rd_dbl = '0;
    logic [NRD-1:0][63:0]  rd_data;
    logic [NRD-1:0]        rd_rsvd;
    logic                  wr_en = 1'b0;
    logic [4:0]            wr_idx = '0;
    logic                  wr_dbl = 1'b0;
    logic [63:0]           wr_data = '0;
    logic                  wr_rsvd;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    logic [31:0] model [32];

    always #4 clk = ~clk;

    pair_rf_unit #(.NRD(NRD)) u_pair_rf_unit (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_dbl(rd_dbl), .rd_data(rd_data), .rd_rsvd(rd_rsvd),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_dbl(wr_dbl), .wr_data(wr_data),
        .wr_rsvd(wr_rsvd)
    );

    function automatic logic [63:0] exp_read(logic [4:0] idx, logic dbl);
        if (!dbl) return {32'h0, (idx == 0) ? 32'h0 : model[idx]};
        if (idx[0] || idx == 0) return 64'h0;
        return {model[idx + 5'd1], model[idx]};
    endfunction

    function automatic string auto_tag(logic [4:0] idx, logic dbl);
        if (dbl && idx[0]) return "R8";
        if (dbl && idx == 0) return "R6";
        if (dbl) return "R4";
        if (idx == 0) return "R3";
        return "R2";
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs are already set after a falling edge; compare, then clock
    task automatic step(string force_tag);
        #1;
        for (int p = 0; p < NRD; p++) begin
            string t = (force_tag != "") ? force_tag : auto_tag(rd_idx[p], rd_dbl[p]);
            check(t, rd_data[p], exp_read(rd_idx[p], rd_dbl[p]));
            check("R8", {63'h0, rd_rsvd[p]}, {63'h0, rd_dbl[p] & rd_idx[p][0]});
        end
        check("R8", {63'h0, wr_rsvd}, {63'h0, wr_en & wr_dbl & wr_idx[0]});
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 32; i++) model[i] = '0;
        end else if (wr_en) begin
            if (!wr_dbl) begin
                if (wr_idx != 0) model[wr_idx] = wr_data[31:0];
            end else if (!wr_idx[0] && wr_idx != 0) begin
                model[wr_idx]        = wr_data[31:0];
                model[wr_idx + 5'd1] = wr_data[63:32];
            end
        end
        @(negedge clk);
    endtask

    task automatic set_wr(logic en, logic [4:0] idx, logic dbl, logic [63:0] d);
        wr_en = en; wr_idx = idx; wr_dbl = dbl; wr_data = d;
    endtask

    task automatic set_rd(int p, logic [4:0] idx, logic dbl);
        rd_idx[p] = idx; rd_dbl[p] = dbl;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 'x;
        @(negedge clk);
        step("");   // reset cycle: model cleared at the edge
        step("");
        rst = 1'b0;

        // R1: every register reads zero after reset
        for (int b = 0; b < 32; b += NRD) begin
            for (int p = 0; p < NRD; p++) set_rd(p, 5'((b + p) % 32), 1'b0);
            step("R1");
        end

        // R2 single write, R10 same-cycle read returns old value
        set_wr(1, 5'd5, 0, 64'hDEAD_BEEF_1234_5678);
        set_rd(0, 5'd5, 0); set_rd(1, 5'd4, 1); set_rd(2, 5'd6, 0);
        step("R10");
        set_wr(0, 0, 0, 0);
        step("R10");

        // R3 single write to x0 discarded
        set_wr(1, 5'd0, 0, 64'h0000_0000_FFFF_FFFF);
        set_rd(0, 5'd0, 0);
        step("R3");
        set_wr(0, 0, 0, 0);
        step("R3");

        // R5 pair write, then R4 pair read and halves singly
        set_wr(1, 5'd14, 1, 64'hAAAA_5555_0F0F_F0F0);
        step("R5");
        set_wr(0, 0, 0, 0);
        set_rd(0, 5'd14, 1); set_rd(1, 5'd14, 0); set_rd(2, 5'd15, 0);
        step("R5");

        // R6 / R7: set x1, then pair read and pair write at index 0
        set_wr(1, 5'd1, 0, 64'h0000_0000_CAFE_F00D);
        step("");
        set_wr(1, 5'd0, 1, 64'h1111_2222_3333_4444);
        set_rd(0, 5'd0, 1); set_rd(1, 5'd1, 0); set_rd(2, 5'd0, 0);
        step("");
        set_wr(0, 0, 0, 0);
        set_rd(0, 5'd1, 0);
        step("R7");

        // R8 / R9: reserved odd pair write leaves 15 and 16 untouched
        set_wr(1, 5'd15, 1, 64'h9999_8888_7777_6666);
        set_rd(0, 5'd15, 1); set_rd(1, 5'd15, 0); set_rd(2, 5'd16, 0);
        step("");
        set_wr(0, 0, 0, 0);
        set_rd(0, 5'd15, 0); set_rd(1, 5'd16, 0); set_rd(2, 5'd14, 0);
        step("R9");

        // R11: three distinct port patterns in one cycle
        set_rd(0, 5'd14, 1); set_rd(1, 5'd5, 0); set_rd(2, 5'd3, 1);
        step("R11");

        // Mixed traffic across all widths and indices
        for (int n = 0; n < 3000; n++) begin
            set_wr($urandom_range(0, 1) == 1, 5'($urandom_range(0, 31)), $urandom_range(0, 1) == 1,
                   {$urandom(), $urandom()});
            for (int p = 0; p < NRD; p++)
                set_rd(p, 5'($urandom_range(0, 31)), $urandom_range(0, 1) == 1);
            step("");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule